// File: doc/BRIEF.md
# Vector Clock Timestamp Unit

This block holds one vector timestamp for each of a small, fixed number of hardware threads. Each vector has one counter for every thread. The vectors move forward only when a thread passes a synchronization point. Each vector therefore names the epoch that a thread spends between two synchronization operations. A lock event carries a thread id and is either a release or an acquire.

On a release, the thread's own counter goes up by one. The updated vector is then presented at the output so the caller can store it in the lock object and append it to a replay log. On an acquire, the caller supplies the vector that was last stored with the lock. The thread's new vector is the element-wise maximum of its own vector and the lock's vector, with the thread's own counter then raised by one.

A separate combinational comparator takes any two vectors. It reports whether the first happened before the second, the second happened before the first, the two are equal, or the two are concurrent. Only concurrent epochs can contain a data race. Any thread's current vector can be read out combinationally through a read-select port.

Top module: `vcTimestampUnit`

## Requirements
- R1: After reset, every counter of every thread's vector reads zero, `relValid` is 0 and `ovfFlag` is 0.
- R2: A release event for thread t raises component t of thread t's vector by one. The new vector is visible on `readVec` in the cycle after the event. All other components, and all other threads' vectors, are left unchanged.
- R3: In the cycle after a release event, `relValid` is 1 for exactly one cycle, `relVec` holds thread t's updated vector and `relTid` holds t.
- R4: An acquire event for thread t sets each component k of thread t's vector to the maximum of the current component and component k of `lockVecIn`. Component t is then raised by one. Example with four threads: thread 1 at (0,0,0,0) acquiring a lock holding (2,0,0,0) ends at (2,1,0,0).
- R5: An acquire event never raises `relValid`.
- R6: When the component to be raised already holds the all-ones maximum, it stays at the maximum instead of wrapping. In that case `ovfFlag` becomes 1 and stays 1 until reset.
- R7: `cmpAbeforeB` is 1 exactly when every component of `cmpA` is less than or equal to the matching component of `cmpB` and at least one is strictly less. `cmpBbeforeA` is the mirror case.
- R8: `cmpEqual` is 1 when all components match. `cmpConcurrent` is 1 when some component of A is larger and some other component is smaller. Exactly one of the four comparator outputs is 1 at any time.
- R9: In cycles without an event, every thread's vector holds its value.
- Vector layout: component k of any flat vector port occupies bits [k*CntWidth +: CntWidth].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | A lock event is presented this cycle |
| evtIsAcquire | input | 1 | 1 = acquire, 0 = release |
| evtTid | input | TidW | Thread executing the event |
| lockVecIn | input | NumThreads*CntWidth | Vector stored with the lock (used on acquire) |
| readTid | input | TidW | Thread whose vector appears on readVec |
| readVec | output | NumThreads*CntWidth | Current vector of thread readTid |
| relValid | output | 1 | One-cycle pulse after a release |
| relTid | output | TidW | Thread of the reported release |
| relVec | output | NumThreads*CntWidth | Vector to store in the lock and append to the log |
| ovfFlag | output | 1 | Sticky counter saturation flag |
| cmpA | input | NumThreads*CntWidth | First comparator operand |
| cmpB | input | NumThreads*CntWidth | Second comparator operand |
| cmpAbeforeB | output | 1 | A happened before B |
| cmpBbeforeA | output | 1 | B happened before A |
| cmpEqual | output | 1 | A and B are identical |
| cmpConcurrent | output | 1 | A and B are unordered |

## Verification
Vector updates, `relValid`, `relTid`, `relVec` and `ovfFlag` all come from registers written at the edge where the event is presented. The bench drives each event at a falling edge and samples all of these results at the next falling edge, which is exactly one clock later. The comparator and the `readVec` path are purely combinational. The bench sets their operands or the read select and samples a fraction of a nanosecond later, all inside the same low clock phase. A bench model tracks every thread's vector and the overflow flag and supplies the expected value for each of these samples.

// File: rtl/vcPkg.sv
package vcPkg;

  // Strobes from control to datapath for one accepted lock event.
  typedef struct packed {
    logic bump;     // update the selected thread's vector
    logic merge;    // fold the lock vector in (acquire)
    logic publish;  // capture the result for export (release)
  } vcStrobe_t;

endpackage

// File: rtl/vcCtrl.sv
module vcCtrl
  import vcPkg::*;
#(
  parameter int NumThreads = 4,
  parameter int TidW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evtValid,
  input  logic            evtIsAcquire,
  input  logic [TidW-1:0] evtTid,
  input  logic            satHit,
  output vcStrobe_t       strobe,
  output logic            relValid,
  output logic [TidW-1:0] relTid,
  output logic            ovfFlag
);

  logic tidOk;

  // Ids beyond the thread count are dropped (only possible for non-power-of-two counts).
  assign tidOk = (int'(evtTid) < NumThreads);

  always_comb begin
    strobe.bump    = evtValid && tidOk;
    strobe.merge   = evtValid && tidOk && evtIsAcquire;
    strobe.publish = evtValid && tidOk && !evtIsAcquire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relValid <= 1'b0;
      relTid   <= '0;
      ovfFlag  <= 1'b0;
    end else begin
      relValid <= strobe.publish;
      if (strobe.publish) relTid <= evtTid;
      if (strobe.bump && satHit) ovfFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/vcDatapath.sv
module vcDatapath
  import vcPkg::*;
#(
  parameter int NumThreads = 4,
  parameter int CntWidth = 8,
  parameter int TidW = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  vcStrobe_t                            strobe,
  input  logic [TidW-1:0]                      evtTid,
  input  logic [NumThreads-1:0][CntWidth-1:0]  lockVec,
  input  logic [TidW-1:0]                      readTid,
  output logic [NumThreads-1:0][CntWidth-1:0]  readVec,
  output logic [NumThreads-1:0][CntWidth-1:0]  relVec,
  output logic                                 satHit
);

  localparam logic [CntWidth-1:0] CntMax = '1;

  typedef logic [NumThreads-1:0][CntWidth-1:0] vec_t;

  vec_t vecQ [NumThreads];
  vec_t ownVec;
  vec_t mergedVec;
  vec_t nextVec;
  vec_t relVecQ;

  assign ownVec = vecQ[evtTid];

  // Element-wise maximum against the lock's vector, only on acquire.
  for (genvar k = 0; k < NumThreads; k++) begin : g_merge
    assign mergedVec[k] = (strobe.merge && (lockVec[k] > ownVec[k])) ? lockVec[k] : ownVec[k];
  end

  assign satHit = (mergedVec[evtTid] == CntMax);

  // Saturating increment of the executing thread's own component.
  always_comb begin
    nextVec = mergedVec;
    if (!satHit) nextVec[evtTid] = mergedVec[evtTid] + 1'b1;
  end

  for (genvar t = 0; t < NumThreads; t++) begin : g_thread
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecQ[t] <= '0;
      end else if (strobe.bump && (evtTid == TidW'(t))) begin
        vecQ[t] <= nextVec;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relVecQ <= '0;
    end else if (strobe.publish) begin
      relVecQ <= nextVec;
    end
  end

  assign relVec  = relVecQ;
  assign readVec = vecQ[readTid];

endmodule

// File: rtl/vcCompare.sv
module vcCompare #(
  parameter int NumThreads = 4,
  parameter int CntWidth = 8
) (
  input  logic [NumThreads-1:0][CntWidth-1:0] vecA,
  input  logic [NumThreads-1:0][CntWidth-1:0] vecB,
  output logic                                aBeforeB,
  output logic                                bBeforeA,
  output logic                                isEqual,
  output logic                                isConcurrent
);

  logic [NumThreads-1:0] aLess;
  logic [NumThreads-1:0] aMore;

  for (genvar k = 0; k < NumThreads; k++) begin : g_cmp
    assign aLess[k] = vecA[k] < vecB[k];
    assign aMore[k] = vecA[k] > vecB[k];
  end

  assign aBeforeB     = (|aLess) && !(|aMore);
  assign bBeforeA     = (|aMore) && !(|aLess);
  assign isEqual      = !(|aLess) && !(|aMore);
  assign isConcurrent = (|aLess) && (|aMore);

endmodule

// File: rtl/vcTimestampUnit.sv
module vcTimestampUnit
  import vcPkg::*;
#(
  parameter int NumThreads = 4,
  parameter int CntWidth = 8,
  localparam int TidW = (NumThreads > 1) ? $clog2(NumThreads) : 1,
  localparam int VecW = NumThreads * CntWidth
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evtValid,
  input  logic            evtIsAcquire,
  input  logic [TidW-1:0] evtTid,
  input  logic [VecW-1:0] lockVecIn,
  input  logic [TidW-1:0] readTid,
  output logic [VecW-1:0] readVec,
  output logic            relValid,
  output logic [TidW-1:0] relTid,
  output logic [VecW-1:0] relVec,
  output logic            ovfFlag,
  input  logic [VecW-1:0] cmpA,
  input  logic [VecW-1:0] cmpB,
  output logic            cmpAbeforeB,
  output logic            cmpBbeforeA,
  output logic            cmpEqual,
  output logic            cmpConcurrent
);

  vcStrobe_t strobe;
  logic      satHit;

  vcCtrl #(
    .NumThreads(NumThreads),
    .TidW(TidW)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .evtValid(evtValid),
    .evtIsAcquire(evtIsAcquire),
    .evtTid(evtTid),
    .satHit(satHit),
    .strobe(strobe),
    .relValid(relValid),
    .relTid(relTid),
    .ovfFlag(ovfFlag)
  );

  vcDatapath #(
    .NumThreads(NumThreads),
    .CntWidth(CntWidth),
    .TidW(TidW)
  ) i_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .evtTid(evtTid),
    .lockVec(lockVecIn),
    .readTid(readTid),
    .readVec(readVec),
    .relVec(relVec),
    .satHit(satHit)
  );

  vcCompare #(
    .NumThreads(NumThreads),
    .CntWidth(CntWidth)
  ) i_cmp (
    .vecA(cmpA),
    .vecB(cmpB),
    .aBeforeB(cmpAbeforeB),
    .bBeforeA(cmpBbeforeA),
    .isEqual(cmpEqual),
    .isConcurrent(cmpConcurrent)
  );

endmodule

// File: rtl/vcTimestampUnitChk.sv
module vcTimestampUnitChk (
  input logic clk,
  input logic rstN,
  input logic evtValid,
  input logic evtIsAcquire,
  input logic relValid,
  input logic ovfFlag,
  input logic cmpAbeforeB,
  input logic cmpBbeforeA,
  input logic cmpEqual,
  input logic cmpConcurrent
);

  assert_rel_after_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> $past(evtValid && !evtIsAcquire));

  assert_acquire_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtIsAcquire) |=> !relValid);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);

  assert_order_antisym_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmpAbeforeB && cmpBbeforeA));

  assert_one_class_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cmpAbeforeB, cmpBbeforeA, cmpEqual, cmpConcurrent}) == 1);

endmodule

bind vcTimestampUnit vcTimestampUnitChk i_chk (
  .clk(clk),
  .rstN(rstN),
  .evtValid(evtValid),
  .evtIsAcquire(evtIsAcquire),
  .relValid(relValid),
  .ovfFlag(ovfFlag),
  .cmpAbeforeB(cmpAbeforeB),
  .cmpBbeforeA(cmpBbeforeA),
  .cmpEqual(cmpEqual),
  .cmpConcurrent(cmpConcurrent)
);

// File: tb/test_vcTimestampUnit.sv
`timescale 1ns/1ps
module test_vcTimestampUnit;

  localparam int NT = 4;
  localparam int CW = 8;
  localparam int TW = 2;
  localparam int MAXV = (1 << CW) - 1;

  typedef logic [NT-1:0][CW-1:0] vec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic evtIsAcquire = 1'b0;
  logic [TW-1:0] evtTid = '0;
  vec_t lockVecIn = '0;
  logic [TW-1:0] readTid = '0;
  vec_t readVec;
  logic relValid;
  logic [TW-1:0] relTid;
  vec_t relVec;
  logic ovfFlag;
  vec_t cmpA = '0;
  vec_t cmpB = '0;
  logic cmpAbeforeB, cmpBbeforeA, cmpEqual, cmpConcurrent;

  int checkCount = 0;
  int failCount = 0;
  vec_t model [NT];
  bit modelOvf;

  always #2.5 clk = ~clk;

  vcTimestampUnit #(.NumThreads(NT), .CntWidth(CW)) i_vcTimestampUnit (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtIsAcquire(evtIsAcquire),
    .evtTid(evtTid), .lockVecIn(lockVecIn), .readTid(readTid), .readVec(readVec),
    .relValid(relValid), .relTid(relTid), .relVec(relVec), .ovfFlag(ovfFlag),
    .cmpA(cmpA), .cmpB(cmpB), .cmpAbeforeB(cmpAbeforeB), .cmpBbeforeA(cmpBbeforeA),
    .cmpEqual(cmpEqual), .cmpConcurrent(cmpConcurrent)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic vec_t nextModel(input vec_t own, input vec_t lock, input bit acq, input int tid, output bit sat);
    vec_t r = own;
    if (acq) for (int k = 0; k < NT; k++) if (lock[k] > r[k]) r[k] = lock[k];
    sat = (int'(r[tid]) == MAXV);
    if (!sat) r[tid] = r[tid] + 1'b1;
    return r;
  endfunction

  // Returns {aBeforeB, bBeforeA, equal, concurrent}.
  function automatic logic [3:0] classify(input vec_t a, input vec_t b);
    bit lt = 0, gt = 0;
    for (int k = 0; k < NT; k++) begin
      if (a[k] < b[k]) lt = 1;
      if (a[k] > b[k]) gt = 1;
    end
    return {lt && !gt, gt && !lt, !lt && !gt, lt && gt};
  endfunction

  task automatic checkVectors(input string req);
    for (int t = 0; t < NT; t++) begin
      readTid = TW'(t);
      #0.1;
      check(readVec === model[t], req, readVec, model[t]);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    evtValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int t = 0; t < NT; t++) model[t] = '0;
    modelOvf = 0;
    #0.1;
    check(relValid === 1'b0, "R1 relValid", relValid, 0);
    check(ovfFlag === 1'b0, "R1 ovfFlag", ovfFlag, 0);
    checkVectors("R1 vectors");
  endtask

  task automatic runEvent(input bit acq, input int tid, input vec_t lock);
    vec_t expVec;
    bit sat;
    expVec = nextModel(model[tid], lock, acq, tid, sat);
    if (sat) modelOvf = 1;
    model[tid] = expVec;
    @(negedge clk);
    evtValid = 1'b1;
    evtIsAcquire = acq;
    evtTid = TW'(tid);
    lockVecIn = lock;
    @(negedge clk);
    evtValid = 1'b0;
    #0.1;
    if (acq) begin
      check(relValid === 1'b0, "R5 no publish on acquire", relValid, 0);
      checkVectors("R4 acquire merge");
    end else begin
      check(relValid === 1'b1, "R3 relValid", relValid, 1);
      check(relVec === expVec, "R3 relVec", relVec, expVec);
      check(relTid === TW'(tid), "R3 relTid", relTid, tid);
      checkVectors("R2 release increment");
    end
    check(ovfFlag === modelOvf, "R6 ovfFlag", ovfFlag, modelOvf);
  endtask

  task automatic runCompare(input vec_t a, input vec_t b);
    logic [3:0] exp;
    logic [3:0] act;
    cmpA = a;
    cmpB = b;
    #0.1;
    exp = classify(a, b);
    act = {cmpAbeforeB, cmpBbeforeA, cmpEqual, cmpConcurrent};
    check(act[3:2] === exp[3:2], "R7 ordering", act, exp);
    check(act[1:0] === exp[1:0], "R8 equal/concurrent", act, exp);
  endtask

  initial begin
    #(200000 * 5);
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    vec_t lv;
    int seedInit;
    seedInit = $urandom(32'h1BADB002);
    doReset();

    // Directed epoch example: T0 locks, unlocks, then T1 acquires the stored vector.
    runEvent(1, 0, '0);
    runEvent(0, 0, '0);
    lv = relVec;
    runEvent(1, 1, lv);
    readTid = 2'd1;
    #0.1;
    check(readVec === vec_t'({8'd0, 8'd0, 8'd1, 8'd2}), "R4 example (2,1,0,0)", readVec, {8'd0, 8'd0, 8'd1, 8'd2});

    // Idle cycles leave every vector untouched.
    repeat (5) @(negedge clk);
    checkVectors("R9 hold when idle");

    // Random mix of lock events.
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < NT; k++) lv[k] = CW'($urandom_range(0, 40));
      runEvent(bit'($urandom_range(0, 1)), int'($urandom_range(0, NT - 1)), lv);
    end

    // Comparator: directed corners, then random small-valued operands.
    runCompare({8'd3, 8'd2, 8'd1, 8'd0}, {8'd3, 8'd2, 8'd1, 8'd0});
    runCompare({8'd3, 8'd2, 8'd1, 8'd0}, {8'd3, 8'd2, 8'd2, 8'd0});
    runCompare({8'd3, 8'd2, 8'd2, 8'd0}, {8'd3, 8'd2, 8'd1, 8'd0});
    runCompare({8'd0, 8'd0, 8'd1, 8'd2}, {8'd0, 8'd0, 8'd2, 8'd1});
    runCompare('0, {8'd255, 8'd255, 8'd255, 8'd255});
    for (int i = 0; i < 200; i++) begin
      vec_t a, b;
      for (int k = 0; k < NT; k++) begin
        a[k] = CW'($urandom_range(0, 3));
        b[k] = CW'($urandom_range(0, 3));
      end
      runCompare(a, b);
    end

    // Saturation: fresh start, then acquire a lock whose own component is at maximum.
    doReset();
    lv = '0;
    lv[2] = 8'hFF;
    runEvent(1, 2, lv);
    readTid = 2'd2;
    #0.1;
    check(readVec[2] === 8'hFF, "R6 saturate no wrap", readVec[2], 8'hFF);
    check(ovfFlag === 1'b1, "R6 overflow raised", ovfFlag, 1);
    runEvent(0, 2, '0);
    runEvent(0, 0, '0);
    runEvent(1, 3, '0);
    repeat (3) @(negedge clk);
    #0.1;
    check(ovfFlag === 1'b1, "R6 overflow sticky", ovfFlag, 1);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule